// File: doc/BRIEF.md
# Instruction-Keyed Stride Prefetcher

This block watches the stream of demand cache-line addresses reaching a memory controller. Each demand carries the address of the instruction that issued it. A small table of stream trackers is keyed by that instruction address, so accesses from unrelated instructions that fall in between never disturb a stream. Each tracker learns a signed stride, counted in whole 64-byte lines. The stride may run upward or downward, and the spacing may wobble by one line between accesses. Once the tracker is confident, the block proposes a line two strides ahead of the latest access.

Proposed lines leave through a valid/ready request port. The line is recorded in a small prefetch buffer local to the controller at the moment the request is accepted. Prefetched data never goes to the core caches; the buffer keeps only line tags and valid bits. A later demand that matches a buffered line raises a one-cycle hit pulse and consumes the entry.

Top module: `pf_stream_prefetch`

## Requirements
- R1: After reset `pfValid` and `bufHit` are low, no stream is tracked and the prefetch buffer is empty.
- R2: A demand from an untracked instruction address allocates a tracker and proposes nothing. The next demand of that tracker sets the stride to the new line delta with confidence 1. A third demand with a matching delta raises confidence to 2 and proposes `line + 2*stride`, with `pfValid` high in the cycle after the demand.
- R3: Ascending (positive stride) and descending (negative stride) streams are both tracked and prefetched.
- R4: Trackers are matched by instruction address only. Demands from other instruction addresses, interleaved between a stream's accesses, leave that stream's prediction unchanged.
- R5: A new delta with the same sign as the stored stride and within one line of it counts as a match: confidence rises (saturating at 3) and the stride becomes the new delta. A same-sign delta further than one line away sets confidence to 0 and adopts the new delta. A delta that does not fit the stride field sets stride and confidence to 0.
- R6: A delta whose sign differs from the stored stride sets confidence to 0 and adopts the new delta, so no prefetch follows until confidence is rebuilt.
- R7: A demand to the same line as the tracker's last line changes neither stride nor confidence and proposes nothing.
- R8: Eight trackers are held. When a new instruction address arrives with all trackers in use, the least recently used tracker is replaced.
- R9: A proposal is dropped if its line is already in the buffer or equals the line currently held on the request port.
- R10: While `pfValid` is high and `pfReady` low, `pfValid` and `pfLine` hold, and new proposals are dropped. A line is written into the buffer when `pfValid` and `pfReady` are both high.
- R11: The buffer holds 16 lines and overwrites its slots in insertion order, oldest first, whether or not a slot is still valid.
- R12: A demand whose line is valid in the buffer raises `bufHit` for exactly the next cycle and invalidates that entry, so a repeat demand does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmdValid | input | 1 | Demand access present this cycle |
| dmdLine | input | 26 | Demand cache-line address (64-byte units) |
| dmdPc | input | 12 | Instruction address tag of the demand |
| pfValid | output | 1 | Prefetch request pending |
| pfReady | input | 1 | Downstream accepts the prefetch request |
| pfLine | output | 26 | Line address to prefetch |
| bufHit | output | 1 | One-cycle pulse: previous demand hit the prefetch buffer |

## Verification
The assertions check on every cycle the handshake discipline of the request port, and that every hit pulse and every fresh request is caused by a demand in the cycle before. They also check that a request accepted back to back is never followed by the same line. Whether the predicted line is correct depends on the stream's history. Tolerance to jitter, sign reversal, replacement of the least recently used tracker and the buffer's insertion order also need that history, so only the bench's scenarios can show them. The bench sweeps strides of both signs and several magnitudes and compares each proposal with the arithmetic projection two strides ahead.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Strobes from the control to the datapath for one demand.
  typedef struct packed {
    logic alloc;   // claim the victim tracker for a new instruction address
    logic update;  // write last line, stride and confidence of the hit tracker
    logic issue;   // a projected line is proposed this cycle
  } pfStrobe_t;

  // How a demand relates to its tracker.
  typedef enum logic [2:0] {
    DC_IDLE,
    DC_ALLOC,
    DC_HOLD,
    DC_RESTART,
    DC_SEED,
    DC_MATCH,
    DC_BREAK
  } deltaClass_e;

endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int STRIDE_W   = 8,
  parameter int CONF_W     = 2,
  parameter int ISSUE_CONF = 2
) (
  input  logic                       dmdValid,
  input  logic [LINE_W-1:0]          dmdLine,
  input  logic                       tagHit,
  input  logic [LINE_W-1:0]          entLast,
  input  logic signed [STRIDE_W-1:0] entStride,
  input  logic [CONF_W-1:0]          entConf,
  output pfStrobe_t                  strobe,
  output logic signed [STRIDE_W-1:0] newStride,
  output logic [CONF_W-1:0]          newConf,
  output logic [LINE_W-1:0]          issueLine
);

  localparam int CONF_MAX = (1 << CONF_W) - 1;
  localparam int EXT_W    = LINE_W - STRIDE_W;

  logic [LINE_W-1:0]          delta;
  logic                       fits;
  logic signed [STRIDE_W-1:0] dNarrow;
  logic signed [STRIDE_W:0]   diff;
  logic                       sameSign;
  logic                       close;
  deltaClass_e                cls;

  assign delta    = dmdLine - entLast;
  assign fits     = (&delta[LINE_W-1:STRIDE_W-1]) | ~(|delta[LINE_W-1:STRIDE_W-1]);
  assign dNarrow  = delta[STRIDE_W-1:0];
  assign diff     = {dNarrow[STRIDE_W-1], dNarrow} - {entStride[STRIDE_W-1], entStride};
  assign sameSign = dNarrow[STRIDE_W-1] == entStride[STRIDE_W-1];
  assign close    = (diff == 0) || (diff == 1) || (diff == -1);

  always_comb begin
    if (!dmdValid)                      cls = DC_IDLE;
    else if (!tagHit)                   cls = DC_ALLOC;
    else if (delta == '0)               cls = DC_HOLD;
    else if (!fits)                     cls = DC_RESTART;
    else if (entStride == '0)           cls = DC_SEED;
    else if (sameSign && close)         cls = DC_MATCH;
    else                                cls = DC_BREAK;
  end

  always_comb begin
    newStride = dNarrow;
    newConf   = '0;
    unique case (cls)
      DC_SEED:    newConf = CONF_W'(1);
      DC_MATCH:   newConf = (entConf == CONF_W'(CONF_MAX)) ? entConf : entConf + 1'b1;
      DC_RESTART: newStride = '0;
      default:    newConf = '0;
    endcase
  end

  assign issueLine = dmdLine + ({{EXT_W{newStride[STRIDE_W-1]}}, newStride} << 1);

  always_comb begin
    strobe.alloc  = cls == DC_ALLOC;
    strobe.update = (cls == DC_RESTART) || (cls == DC_SEED) ||
                    (cls == DC_MATCH)   || (cls == DC_BREAK);
    strobe.issue  = (cls == DC_MATCH) && (newConf >= CONF_W'(ISSUE_CONF));
  end

endmodule

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int PC_W        = 12,
  parameter int STRIDE_W    = 8,
  parameter int CONF_W      = 2,
  parameter int NUM_STREAMS = 8,
  parameter int BUF_DEPTH   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dmdValid,
  input  logic [LINE_W-1:0]          dmdLine,
  input  logic [PC_W-1:0]            dmdPc,
  output logic                       tagHit,
  output logic [LINE_W-1:0]          entLast,
  output logic signed [STRIDE_W-1:0] entStride,
  output logic [CONF_W-1:0]          entConf,
  input  pfStrobe_t                  strobe,
  input  logic signed [STRIDE_W-1:0] newStride,
  input  logic [CONF_W-1:0]          newConf,
  input  logic [LINE_W-1:0]          issueLine,
  output logic                       pfValid,
  input  logic                       pfReady,
  output logic [LINE_W-1:0]          pfLine,
  output logic                       bufHit
);

  localparam int IDX_W = $clog2(NUM_STREAMS);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  // Stream tracker table
  logic [NUM_STREAMS-1:0]     stValid;
  logic [PC_W-1:0]            stPc     [NUM_STREAMS];
  logic [LINE_W-1:0]          stLast   [NUM_STREAMS];
  logic signed [STRIDE_W-1:0] stStride [NUM_STREAMS];
  logic [CONF_W-1:0]          stConf   [NUM_STREAMS];
  logic [IDX_W-1:0]           stAge    [NUM_STREAMS];

  // Prefetch buffer: tags only
  logic [LINE_W-1:0]    bufTag [BUF_DEPTH];
  logic [BUF_DEPTH-1:0] bufVld;
  logic [PTR_W-1:0]     wrPtr;

  logic [NUM_STREAMS-1:0] pcMatch;
  logic [BUF_DEPTH-1:0]   dmdMatch;
  logic [BUF_DEPTH-1:0]   candMatch;
  logic [IDX_W-1:0]       hitIdx, victimIdx, selIdx, selAge;
  logic                   loadPf;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_tag
    assign pcMatch[i] = stValid[i] && (stPc[i] == dmdPc);
  end

  for (genvar j = 0; j < BUF_DEPTH; j++) begin : g_buf
    assign dmdMatch[j]  = bufVld[j] && (bufTag[j] == dmdLine);
    assign candMatch[j] = bufVld[j] && (bufTag[j] == issueLine);
  end

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (pcMatch[i]) hitIdx = IDX_W'(i);
      if (stAge[i] == IDX_W'(NUM_STREAMS - 1)) victimIdx = IDX_W'(i);
    end
  end

  assign tagHit    = |pcMatch;
  assign selIdx    = tagHit ? hitIdx : victimIdx;
  assign selAge    = stAge[selIdx];
  assign entLast   = stLast[hitIdx];
  assign entStride = stStride[hitIdx];
  assign entConf   = stConf[hitIdx];

  assign loadPf = strobe.issue && !(|candMatch) &&
                  !(pfValid && (pfLine == issueLine)) &&
                  (!pfValid || pfReady);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        stPc[i]     <= '0;
        stLast[i]   <= '0;
        stStride[i] <= '0;
        stConf[i]   <= '0;
        stAge[i]    <= IDX_W'(i);
      end
      for (int j = 0; j < BUF_DEPTH; j++) bufTag[j] <= '0;
      stValid <= '0;
      bufVld  <= '0;
      wrPtr   <= '0;
      pfValid <= 1'b0;
      pfLine  <= '0;
      bufHit  <= 1'b0;
    end else begin
      bufHit <= dmdValid && (|dmdMatch);
      if (dmdValid) begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
          if (IDX_W'(i) == selIdx)  stAge[i] <= '0;
          else if (stAge[i] < selAge) stAge[i] <= stAge[i] + 1'b1;
        end
        bufVld <= bufVld & ~dmdMatch;
      end
      if (strobe.alloc) begin
        stValid[selIdx]  <= 1'b1;
        stPc[selIdx]     <= dmdPc;
        stLast[selIdx]   <= dmdLine;
        stStride[selIdx] <= '0;
        stConf[selIdx]   <= '0;
      end
      if (strobe.update) begin
        stLast[selIdx]   <= dmdLine;
        stStride[selIdx] <= newStride;
        stConf[selIdx]   <= newConf;
      end
      if (pfValid && pfReady) begin
        bufTag[wrPtr] <= pfLine;
        bufVld[wrPtr] <= 1'b1;
        wrPtr <= (wrPtr == PTR_W'(BUF_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (loadPf) begin
        pfValid <= 1'b1;
        pfLine  <= issueLine;
      end else if (pfReady) begin
        pfValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pf_stream_prefetch.sv
module pf_stream_prefetch
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int PC_W        = 12,
  parameter int STRIDE_W    = 8,
  parameter int CONF_W      = 2,
  parameter int ISSUE_CONF  = 2,
  parameter int NUM_STREAMS = 8,
  parameter int BUF_DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmdValid,
  input  logic [LINE_W-1:0] dmdLine,
  input  logic [PC_W-1:0]   dmdPc,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [LINE_W-1:0] pfLine,
  output logic              bufHit
);

  pfStrobe_t                  strobe;
  logic                       tagHit;
  logic [LINE_W-1:0]          entLast;
  logic signed [STRIDE_W-1:0] entStride;
  logic [CONF_W-1:0]          entConf;
  logic signed [STRIDE_W-1:0] newStride;
  logic [CONF_W-1:0]          newConf;
  logic [LINE_W-1:0]          issueLine;

  pf_ctrl #(
    .LINE_W(LINE_W), .STRIDE_W(STRIDE_W), .CONF_W(CONF_W), .ISSUE_CONF(ISSUE_CONF)
  ) u_ctrl (
    .dmdValid(dmdValid), .dmdLine(dmdLine), .tagHit(tagHit),
    .entLast(entLast), .entStride(entStride), .entConf(entConf),
    .strobe(strobe), .newStride(newStride), .newConf(newConf), .issueLine(issueLine)
  );

  pf_datapath #(
    .LINE_W(LINE_W), .PC_W(PC_W), .STRIDE_W(STRIDE_W), .CONF_W(CONF_W),
    .NUM_STREAMS(NUM_STREAMS), .BUF_DEPTH(BUF_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dmdValid(dmdValid), .dmdLine(dmdLine), .dmdPc(dmdPc),
    .tagHit(tagHit), .entLast(entLast), .entStride(entStride), .entConf(entConf),
    .strobe(strobe), .newStride(newStride), .newConf(newConf), .issueLine(issueLine),
    .pfValid(pfValid), .pfReady(pfReady), .pfLine(pfLine), .bufHit(bufHit)
  );

endmodule

// File: rtl/pf_stream_prefetch_chk.sv
module pf_stream_prefetch_chk #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmdValid,
  input logic              pfValid,
  input logic              pfReady,
  input logic [LINE_W-1:0] pfLine,
  input logic              bufHit
);

  // R10: a stalled request keeps its line
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> pfValid && $stable(pfLine));

  // R12: a hit pulse follows a demand
  a_r12_hit_after_demand: assert property (@(posedge clk) disable iff (!rstN)
    bufHit |-> $past(dmdValid));

  // R2: a freshly loaded request follows a demand
  a_r2_issue_after_demand: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !($past(pfValid) && !$past(pfReady)) |-> $past(dmdValid));

  // R9: the line just accepted is never re-proposed at once
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && $past(pfValid && pfReady) |-> pfLine != $past(pfLine));

endmodule

bind pf_stream_prefetch pf_stream_prefetch_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .dmdValid(dmdValid), .pfValid(pfValid),
  .pfReady(pfReady), .pfLine(pfLine), .bufHit(bufHit)
);

// File: tb/tb_pf_stream_prefetch.sv
module tb_pf_stream_prefetch;

  localparam int LINE_W = 26;
  localparam int PC_W   = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dmdValid = 1'b0;
  logic [LINE_W-1:0] dmdLine = '0;
  logic [PC_W-1:0]   dmdPc = '0;
  logic              pfValid;
  logic              pfReady = 1'b1;
  logic [LINE_W-1:0] pfLine;
  logic              bufHit;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic              obsPfV, obsHit, obsHit2;
  logic [LINE_W-1:0] obsPfL;

  always #4 clk = ~clk;

  pf_stream_prefetch dut (
    .clk(clk), .rstN(rstN), .dmdValid(dmdValid), .dmdLine(dmdLine), .dmdPc(dmdPc),
    .pfValid(pfValid), .pfReady(pfReady), .pfLine(pfLine), .bufHit(bufHit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dmdValid = 1'b0; pfReady = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // One demand cycle, outputs sampled after its edge, then one idle cycle.
  task automatic touch(input int pc, input int line);
    dmdValid = 1'b1; dmdPc = PC_W'(pc); dmdLine = LINE_W'(line);
    @(negedge clk);
    dmdValid = 1'b0;
    obsPfV = pfValid; obsPfL = pfLine; obsHit = bufHit;
    @(negedge clk);
    obsHit2 = bufHit;
  endtask

  task automatic expPf(input string req, input int line);
    chk(obsPfV === 1'b1, req, int'(obsPfV), 1);
    chk(obsPfL === LINE_W'(line), req, int'(obsPfL), line);
  endtask

  task automatic expNoPf(input string req);
    chk(obsPfV === 1'b0, req, int'(obsPfV), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset();
    chk(pfValid === 1'b0, "R1 pfValid", int'(pfValid), 0);
    chk(bufHit === 1'b0, "R1 bufHit", int'(bufHit), 0);
    touch(5, 77);
    chk(obsHit === 1'b0, "R1 empty buffer", int'(obsHit), 0);
    expNoPf("R2 first access allocates");

    // R2 R3 R12: sweep strides of both signs
    for (int s = -3; s <= 3; s++) begin
      if (s == 0) continue;
      doReset();
      for (int k = 0; k < 8; k++) begin
        touch(40, 5000 + k * s);
        if (k < 2) expNoPf("R2 warm-up");
        else expPf((s > 0) ? "R3 ascending" : "R3 descending", 5000 + (k + 2) * s);
        chk(obsHit === (k >= 4), "R12 hit on prefetched line", int'(obsHit), int'(k >= 4));
        chk(obsHit2 === 1'b0, "R12 single-cycle pulse", int'(obsHit2), 0);
      end
    end

    // R12: consumed entry does not hit again
    doReset();
    for (int k = 0; k < 3; k++) touch(1, 100 + k);
    touch(2, 104);
    chk(obsHit === 1'b1, "R12 hit", int'(obsHit), 1);
    touch(3, 104);
    chk(obsHit === 1'b0, "R12 invalidated after hit", int'(obsHit), 0);

    // R4: interleaved streams with unrelated noise
    doReset();
    for (int k = 0; k < 6; k++) begin
      touch(10, 2000 + 2 * k);
      if (k >= 2) expPf("R4 stream A", 2000 + 2 * (k + 2));
      touch(7, (k % 2 == 0) ? 9000 : 9050);
      touch(11, 3000 - k);
      if (k >= 2) expPf("R4 stream B", 3000 - (k + 2));
    end

    // R5: jitter within one line tolerated
    doReset();
    touch(20, 100); touch(20, 103); expNoPf("R5 seed");
    touch(20, 107); expPf("R5 jitter +1", 115);
    touch(20, 110); expPf("R5 jitter -1", 116);
    // R5: jitter of two lines resets confidence
    touch(21, 200); touch(21, 202);
    touch(21, 206); expNoPf("R5 far delta resets");
    touch(21, 210); expNoPf("R5 rebuilding confidence");
    touch(21, 214); expPf("R5 rebuilt", 222);

    // R6: sign change
    doReset();
    touch(30, 300); touch(30, 302);
    touch(30, 304); expPf("R6 before reversal", 308);
    touch(30, 302); expNoPf("R6 reversal resets");
    touch(30, 300); expNoPf("R6 confidence 1");
    touch(30, 298); expPf("R6 descending after reversal", 294);

    // R7: repeated line is ignored
    doReset();
    touch(31, 400); touch(31, 401);
    touch(31, 402); expPf("R7 baseline", 404);
    touch(31, 402); expNoPf("R7 zero delta no prefetch");
    touch(31, 403); expPf("R7 confidence kept", 405);

    // R8: LRU replacement among eight trackers
    doReset();
    for (int p = 1; p <= 8; p++) touch(p, 1000 * p);
    touch(9, 50000);
    touch(1, 1002);
    touch(1, 1004); expNoPf("R8 oldest tracker was replaced");
    touch(1, 1006); expPf("R8 reallocated stream", 1010);
    touch(8, 8003);
    touch(8, 8006); expPf("R8 recent tracker retained", 8012);

    // R9: duplicate of a buffered line is skipped
    doReset();
    touch(1, 100); touch(1, 101);
    touch(1, 102); expPf("R9 first stream", 104);
    touch(2, 96); touch(2, 98);
    touch(2, 100); expNoPf("R9 line already buffered");
    touch(2, 102); expPf("R9 next line issued", 106);

    // R10: back-pressure holds and drops
    doReset();
    pfReady = 1'b0;
    touch(1, 0); touch(1, 1);
    touch(1, 2); expPf("R10 request raised", 4);
    touch(1, 3); expPf("R10 held under stall", 4);
    pfReady = 1'b1;
    @(negedge clk);
    touch(5, 5);
    chk(obsHit === 1'b0, "R10 stalled proposal dropped", int'(obsHit), 0);
    touch(5, 4);
    chk(obsHit === 1'b1, "R10 accepted line buffered", int'(obsHit), 1);

    // R11: FIFO overwrite after sixteen slots
    doReset();
    for (int k = 0; k < 4; k++) touch(1, k);
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 4; k++) touch(16 + j, 1000 + 100 * j + k);
    touch(99, 4);
    chk(obsHit === 1'b0, "R11 oldest slot overwritten", int'(obsHit), 0);
    touch(98, 5);
    chk(obsHit === 1'b0, "R11 second slot overwritten", int'(obsHit), 0);
    touch(97, 1004);
    chk(obsHit === 1'b1, "R11 third insertion kept", int'(obsHit), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule